// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of a frequency synthesizer, built as synchronous logic on the high-rate clock. A prescaler runs with two moduli, 8 and 9. A swallow count `A` and a program count `M` steer it: for the first `A` sub-cycles of every output period the prescaler counts 9 input clocks, and for the remaining `M − A` sub-cycles it counts 8. The overall ratio is N = 9·A + 8·(M − A). One pulse appears on `fbPulse` per output period, and that pulse goes to the phase comparator.

A second, independent counter divides the reference path. It counts single-cycle `refTick` strobes and emits one `refPulse` for every `R` ticks. Both dividers take new settings from their configuration inputs only at the boundary of a complete output period, so a period is never cut short. A strap input picks one of two power-on channel settings for the feedback divider. The reference divider stays silent while its ratio is zero.

Top module: `pulse_swallow_divider`

## Requirements
- R1: While `rstN` is low at a clock edge, both outputs are low after that edge. The first feedback period after reset uses the strap defaults and ignores `cfgA`/`cfgM`. With `strapSel`=0 these are A=1, M=469, so N=3753. With `strapSel`=1 they are A=7, M=461, so N=3695.
- R2: With constant `cfgA` (3 bits, 0..7) and `cfgM` (10 bits), `fbPulse` is high once every N = 9·A + 8·(M − A) clock cycles. For legal inputs, N stays in the range 56..8191.
- R3: The ratio extremes are exact. A=0, M=7 gives 56. A=7, M=7 gives 63. A=7, M=1023 gives 8191. A=0, M=1023 gives 8184.
- R4: A `cfgM` value below 7 is handled as 7. For example, A=2 with M=3 gives N=58.
- R5: `fbPulse` lasts exactly one clock cycle. It is high in the cycle that follows the edge ending the N-th input cycle of a period. The first pulse after reset release therefore comes in the cycle after the N-th edge.
- R6: A change of `cfgA`/`cfgM` in the middle of a period does not alter that period. The new ratio applies from the following period on.
- R7: For a nonzero active ratio R (`cfgR`, 10 bits), `refPulse` is high for one cycle after every R-th clock edge that samples `refTick` high. With R=1, each tick produces a pulse.
- R8: While the active reference ratio is zero, `refPulse` stays low. The active value is refreshed from `cfgR` on every clock while it is zero. The active reference ratio is zero after reset.
- R9: A change of a nonzero `cfgR` in the middle of a reference period does not alter that period. The new ratio applies after the next `refPulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate divider clock |
| rstN | input | 1 | Synchronous reset, active low |
| strapSel | input | 1 | Chooses one of the two power-on channel settings |
| cfgA | input | 3 | Swallow count A |
| cfgM | input | 10 | Program count M |
| cfgR | input | 10 | Reference ratio R, where 0 turns the reference output off |
| refTick | input | 1 | One-cycle strobe per reference clock period |
| fbPulse | output | 1 | One pulse per N clock cycles |
| refPulse | output | 1 | One pulse per R reference ticks |

## Verification
The hardest case to reach from the ports is a configuration write that lands partway through a period, combined with the ratio extremes where the swallow phase fills a whole period (A = M = 7) or does not occur at all (A = 0). The stimulus first waits for a pulse and then counts a fixed number of cycles. It changes the settings at that point and times the rest of the period. This shows that the running period keeps its old length and that the next period takes the new one. A per-clock reference model sees the same writes, so it also catches an early load that would shorten only a single sub-cycle.

// File: rtl/swallow_pkg.sv
package swallow_pkg;

  // Strobes issued by the control to the counting datapath.
  typedef struct packed {
    logic cycleEnd;  // last input cycle of a full output period
    logic subStep;   // last input cycle of a prescaler sub-cycle
  } ctrlStrobe_t;

  // Terminal flags reported by the datapath.
  typedef struct packed {
    logic preAtLow;     // prescaler at its last count for the low modulus
    logic preAtHigh;    // prescaler at its last count for the high modulus
    logic swallowLive;  // swallow sub-cycles still outstanding
    logic lastSub;      // current sub-cycle is the last of the period
  } dpStatus_t;

  typedef enum logic {
    MOD_LOW  = 1'b0,
    MOD_HIGH = 1'b1
  } modSel_e;

endpackage

// File: rtl/swallow_datapath.sv
module swallow_datapath
  import swallow_pkg::*;
#(
  parameter int A_W     = 3,
  parameter int M_W     = 10,
  parameter int PRE_LOW = 8,
  parameter int M_MIN   = 7,
  parameter int RST_A0  = 1,
  parameter int RST_M0  = 469,
  parameter int RST_A1  = 7,
  parameter int RST_M1  = 461
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           strapSel,
  input  logic [A_W-1:0] cfgA,
  input  logic [M_W-1:0] cfgM,
  input  ctrlStrobe_t    strobe,
  output dpStatus_t      status
);

  localparam int PRE_W = $clog2(PRE_LOW + 1);
  localparam logic [PRE_W-1:0] PRE_LAST_LOW  = PRE_W'(PRE_LOW - 1);
  localparam logic [PRE_W-1:0] PRE_LAST_HIGH = PRE_W'(PRE_LOW);
  localparam logic [M_W-1:0]   M_FLOOR = M_W'(M_MIN);
  localparam logic [A_W-1:0]   STRAP_A0 = A_W'(RST_A0);
  localparam logic [A_W-1:0]   STRAP_A1 = A_W'(RST_A1);
  localparam logic [M_W-1:0]   STRAP_M0 = M_W'(RST_M0);
  localparam logic [M_W-1:0]   STRAP_M1 = M_W'(RST_M1);

  logic [PRE_W-1:0] preCnt;
  logic [M_W-1:0]   subCnt;
  logic [M_W-1:0]   activeM;
  logic [A_W-1:0]   swLeft;
  logic [M_W-1:0]   mLegal;

  // Program counts below the floor are raised to the floor.
  always_comb begin
    mLegal = (cfgM < M_FLOOR) ? M_FLOOR : cfgM;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      subCnt  <= '0;
      activeM <= strapSel ? STRAP_M1 : STRAP_M0;
      swLeft  <= strapSel ? STRAP_A1 : STRAP_A0;
    end else if (strobe.cycleEnd) begin
      preCnt  <= '0;
      subCnt  <= '0;
      activeM <= mLegal;
      swLeft  <= cfgA;
    end else if (strobe.subStep) begin
      preCnt <= '0;
      subCnt <= subCnt + 1'b1;
      if (swLeft != '0) begin
        swLeft <= swLeft - 1'b1;
      end
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_comb begin
    status.preAtLow    = (preCnt == PRE_LAST_LOW);
    status.preAtHigh   = (preCnt == PRE_LAST_HIGH);
    status.swallowLive = (swLeft != '0);
    status.lastSub     = (subCnt == activeM - 1'b1);
  end

endmodule

// File: rtl/swallow_ctrl.sv
module swallow_ctrl
  import swallow_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        fbPulse
);

  modSel_e modSel;
  logic    preTerm;

  // Swallow sub-cycles use the high modulus; the rest use the low one.
  always_comb begin
    modSel  = status.swallowLive ? MOD_HIGH : MOD_LOW;
    preTerm = (modSel == MOD_HIGH) ? status.preAtHigh : status.preAtLow;
    strobe.cycleEnd = preTerm & status.lastSub;
    strobe.subStep  = preTerm & ~status.lastSub;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fbPulse <= 1'b0;
    end else begin
      fbPulse <= strobe.cycleEnd;
    end
  end

endmodule

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int R_W = 10
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           refTick,
  input  logic [R_W-1:0] cfgR,
  output logic           refPulse
);

  logic [R_W-1:0] activeR;
  logic [R_W-1:0] tickCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeR  <= '0;
      tickCnt  <= '0;
      refPulse <= 1'b0;
    end else if (activeR == '0) begin
      // Output gated off; keep picking up the programmed ratio.
      activeR  <= cfgR;
      tickCnt  <= '0;
      refPulse <= 1'b0;
    end else if (refTick) begin
      if (tickCnt == activeR - 1'b1) begin
        tickCnt  <= '0;
        activeR  <= cfgR;
        refPulse <= 1'b1;
      end else begin
        tickCnt  <= tickCnt + 1'b1;
        refPulse <= 1'b0;
      end
    end else begin
      refPulse <= 1'b0;
    end
  end

endmodule

// File: rtl/pulse_swallow_divider.sv
module pulse_swallow_divider
  import swallow_pkg::*;
#(
  parameter int A_W     = 3,
  parameter int M_W     = 10,
  parameter int R_W     = 10,
  parameter int PRE_LOW = 8,
  parameter int M_MIN   = 7,
  parameter int RST_A0  = 1,
  parameter int RST_M0  = 469,
  parameter int RST_A1  = 7,
  parameter int RST_M1  = 461
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           strapSel,
  input  logic [A_W-1:0] cfgA,
  input  logic [M_W-1:0] cfgM,
  input  logic [R_W-1:0] cfgR,
  input  logic           refTick,
  output logic           fbPulse,
  output logic           refPulse
);

  localparam int A_MAX = (1 << A_W) - 1;
  localparam int M_MAX = (1 << M_W) - 1;
  localparam int N_MIN = PRE_LOW * M_MIN;
  localparam int N_MAX = (PRE_LOW + 1) * A_MAX + PRE_LOW * (M_MAX - A_MAX);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  swallow_datapath #(
    .A_W(A_W), .M_W(M_W), .PRE_LOW(PRE_LOW), .M_MIN(M_MIN),
    .RST_A0(RST_A0), .RST_M0(RST_M0), .RST_A1(RST_A1), .RST_M1(RST_M1)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strapSel(strapSel),
    .cfgA(cfgA), .cfgM(cfgM), .strobe(strobe), .status(status)
  );

  swallow_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .status(status),
    .strobe(strobe), .fbPulse(fbPulse)
  );

  ref_divider #(.R_W(R_W)) u_refdiv (
    .clk(clk), .rstN(rstN), .refTick(refTick),
    .cfgR(cfgR), .refPulse(refPulse)
  );

endmodule

// File: rtl/swallow_divider_checker.sv
module swallow_divider_checker #(
  parameter int N_MIN = 56,
  parameter int N_MAX = 8191
) (
  input logic clk,
  input logic rstN,
  input logic fbPulse,
  input logic refPulse,
  input logic refTick
);

  localparam int GAP_W = $clog2(N_MAX + 2);
  localparam logic [GAP_W-1:0] GAP_TOP = '1;

  logic [GAP_W-1:0] gap;
  logic             seenPulse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gap       <= '0;
      seenPulse <= 1'b0;
    end else if (fbPulse) begin
      gap       <= '0;
      seenPulse <= 1'b1;
    end else if (gap != GAP_TOP) begin
      gap <= gap + 1'b1;
    end
  end

  // R2: no period exceeds the largest legal ratio
  a_r2_period_max: assert property (@(posedge clk) disable iff (!rstN)
    gap <= GAP_W'(N_MAX));

  // R2: no period is shorter than the smallest legal ratio
  a_r2_period_min: assert property (@(posedge clk) disable iff (!rstN)
    (fbPulse && seenPulse) |-> (gap >= GAP_W'(N_MIN - 1)));

  // R5: feedback pulse is a single cycle wide
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    fbPulse |=> !fbPulse);

  // R7: a reference pulse always follows a sampled tick
  a_r7_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    refPulse |-> $past(refTick));

endmodule

bind pulse_swallow_divider swallow_divider_checker #(
  .N_MIN(N_MIN), .N_MAX(N_MAX)
) u_checker (
  .clk(clk), .rstN(rstN), .fbPulse(fbPulse),
  .refPulse(refPulse), .refTick(refTick)
);

// File: tb/pulse_swallow_divider_bench.sv
module pulse_swallow_divider_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       strapSel = 1'b0;
  logic [2:0] cfgA = '0;
  logic [9:0] cfgM = 10'd7;
  logic [9:0] cfgR = '0;
  logic       refTick = 1'b0;
  logic       fbPulse;
  logic       refPulse;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string fbTag = "R1";
  string refTag = "R8";

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_swallow_divider u_pulse_swallow_divider (
    .clk(clk), .rstN(rstN), .strapSel(strapSel),
    .cfgA(cfgA), .cfgM(cfgM), .cfgR(cfgR), .refTick(refTick),
    .fbPulse(fbPulse), .refPulse(refPulse)
  );

  function automatic int ratioOf(int a, int m);
    int mm = (m < 7) ? 7 : m;
    return 9 * a + 8 * (mm - a);
  endfunction

  // Behavioural reference model, advanced on each rising edge.
  int  mCnt, mCurN, mRcnt, mCurR;
  bit  expFb, expRef;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0;
      mCurN = strapSel ? ratioOf(7, 461) : ratioOf(1, 469);
      expFb = 0;
      mRcnt = 0;
      mCurR = 0;
      expRef = 0;
    end else begin
      mCnt++;
      if (mCnt == mCurN) begin
        expFb = 1;
        mCnt = 0;
        mCurN = ratioOf(cfgA, cfgM);
      end else begin
        expFb = 0;
      end
      if (mCurR == 0) begin
        mCurR = cfgR;
        mRcnt = 0;
        expRef = 0;
      end else if (refTick) begin
        mRcnt++;
        if (mRcnt == mCurR) begin
          expRef = 1;
          mRcnt = 0;
          mCurR = cfgR;
        end else begin
          expRef = 0;
        end
      end else begin
        expRef = 0;
      end
    end
  end

  // Per-clock comparison, away from the active edge.
  always @(negedge clk) begin
    if (!finished) begin
      compared++;
      if (fbPulse !== expFb) begin
        mismatched++;
        $display("FAIL %s fbPulse at %0t: actual %0b expected %0b", fbTag, $time, fbPulse, expFb);
      end
      compared++;
      if (refPulse !== expRef) begin
        mismatched++;
        $display("FAIL %s refPulse at %0t: actual %0b expected %0b", refTag, $time, refPulse, expRef);
      end
    end
  end

  // Reference tick: one cycle in three.
  int tickPhase = 0;
  always @(negedge clk) begin
    tickPhase = (tickPhase == 2) ? 0 : tickPhase + 1;
    refTick <= (tickPhase == 0);
  end

  task automatic check(string tag, int actual, int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic waitFb();
    do @(negedge clk); while (!fbPulse);
  endtask

  task automatic waitRef();
    do @(negedge clk); while (!refPulse);
  endtask

  task automatic gapFb(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!fbPulse);
  endtask

  task automatic gapRef(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!refPulse);
  endtask

  task automatic runCfg(int a, int m, string tag);
    int g;
    @(negedge clk);
    cfgA = 3'(a);
    cfgM = 10'(m);
    fbTag = tag;
    waitFb();
    gapFb(g);
    check(tag, g, ratioOf(a, m));
  endtask

  task automatic doReset(bit strap, string tag);
    int g;
    @(negedge clk);
    rstN = 1'b0;
    strapSel = strap;
    fbTag = tag;
    repeat (3) @(negedge clk);
    check({tag, " fbPulse in reset"}, int'(fbPulse), 0);
    check({tag, " refPulse in reset"}, int'(refPulse), 0);
    rstN = 1'b1;
    gapFb(g);
    check({tag, " first period"}, g, strap ? 3695 : 3753);
  endtask

  initial begin
    int g;
    int cnt;
    // R1: strap 0 default period; cfg differs to show it is ignored
    cfgA = 3'd3;
    cfgM = 10'd20;
    doReset(1'b0, "R1");
    fbTag = "R2";
    waitFb();
    gapFb(g);
    check("R2 ratio A=3 M=20", g, 163);

    // R3: extremes
    runCfg(0, 7, "R3");
    runCfg(7, 7, "R3");
    runCfg(7, 1023, "R3");
    runCfg(0, 1023, "R3");

    // R4: program counts below the floor
    runCfg(2, 3, "R4");
    runCfg(7, 0, "R4");

    // R2: random legal settings
    for (int i = 0; i < 8; i++) begin
      runCfg($urandom_range(0, 7), $urandom_range(7, 150), "R2");
    end

    // R6: mid-period change keeps the running period
    runCfg(2, 10, "R6");
    waitFb();
    repeat (20) @(negedge clk);
    cfgA = 3'd5;
    cfgM = 10'd30;
    g = 20;
    do begin @(negedge clk); g++; end while (!fbPulse);
    check("R6 running period kept", g, 82);
    gapFb(g);
    check("R6 new period", g, 245);

    // R8: ratio zero keeps the reference silent
    refTag = "R8";
    cnt = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (refPulse) cnt++;
    end
    check("R8 no pulses with R=0", cnt, 0);

    // R7: reference ratios (tick every 3 cycles)
    refTag = "R7";
    cfgR = 10'd4;
    waitRef();
    gapRef(g);
    check("R7 R=4 gap", g, 12);
    cfgR = 10'd1;
    waitRef();
    gapRef(g);
    check("R7 R=1 gap", g, 3);

    // R9: mid-period reference change
    refTag = "R9";
    cfgR = 10'd4;
    waitRef();
    waitRef();
    repeat (4) @(negedge clk);
    cfgR = 10'd2;
    g = 4;
    do begin @(negedge clk); g++; end while (!refPulse);
    check("R9 running ref period kept", g, 12);
    gapRef(g);
    check("R9 new ref period", g, 6);

    // R8: back to zero silences the output after the current period
    refTag = "R8";
    cfgR = 10'd0;
    waitRef();
    cnt = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (refPulse) cnt++;
    end
    check("R8 silent after return to zero", cnt, 0);

    // R1: strap 1 default period
    doReset(1'b1, "R1");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule